// File: doc/BRIEF.md
# External Memory Bus Controller

This block connects an internal request port (valid/ready) to an external byte-wide SRAM over a multiplexed bus. The low address byte and the data share one set of lines. A separate byte carries the high address. An address-latch strobe and active-low write and read strobes complete the bus. Each access starts with one address phase and then a strobe phase. The strobe phase can be stretched by wait states.

Software configures the block through two 8-bit control registers. The external range can be split into a lower and an upper sector, each with its own 2-bit wait field, and the boundary between them is programmable. A legacy mode replaces both sectors with a single wait bit. While the enable bit is set, the block raises a pin-override flag and output enables so that it owns the bus pins. When the bit is clear, the pins go back to ordinary port control.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: After reset both control registers read 0x00, pin_override and hi_oe are 0, ale is 0, wr_n and rd_n are 1, ad_oe is 0 and no request is accepted.
- R2: CTRL register (cfg_sel=0) bit 7 is the enable; pin_override and hi_oe equal it. While it is 0 a pending request is never started: ale stays 0, wr_n and rd_n stay 1 and ad_oe stays 0.
- R3: An accepted request produces, in the cycle after acceptance, exactly one address cycle. In that cycle ale=1, ad_oe=1, ad_out holds address bits 7:0 and a_hi holds address bits 15:8. ale is 0 in every strobe cycle that follows, and a_hi keeps the high byte until the access ends.
- R4: A write drives wr_n low for 1+W cycles with the write data on ad_out and ad_oe=1. It then holds the data (ad_oe=1, wr_n=1) for one more cycle, and req_ready is 1 in that hold cycle.
- R5: A read sets ad_oe=0 after the address cycle and drives rd_n low for 1+W cycles. In the last rd_n cycle req_ready is 1 and req_rdata equals ad_in; at all other times req_rdata is 0.
- R6: Wait-field code W: 00 → 0 extra strobe cycles, 01 → 1, 10 → 2, 11 → 2 plus one idle cycle after the ready cycle, during which no new address is driven.
- R7: SECT register (cfg_sel=1) bits 6:4 are the sector limit L, bits 3:2 the lower-sector wait field and bits 1:0 the upper-sector wait field. For L in 1..7, addresses below L×0x2000 use the lower field and all others use the upper field.
- R8: With L=0 every address uses the upper-sector wait field (bits 1:0).
- R9: CTRL bit 0 selects legacy mode. In that mode CTRL bit 6 alone sets the wait count for every address (1 → one extra strobe cycle, 0 → none), and the sector fields are ignored.
- R10: Reserved bits (CTRL bits 5:1 and SECT bit 7) always read 0, and writing ones to them has no effect.
- R11: req_ready is a single-cycle pulse per access. A request held valid across the ready cycle is not started until the controller is free again (after the idle cycle when W=11).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_sel | input | 1 | Register select: 0 = CTRL, 1 = SECT |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Readback of the selected register |
| req_valid | input | 1 | Access request valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 8 | Read data, valid with req_ready on reads |
| ad_out | output | 8 | Shared address-low/data bus, output side |
| ad_in | input | 8 | Shared bus, input side |
| ad_oe | output | 1 | Output enable for the shared bus |
| a_hi | output | 8 | High address byte |
| ale | output | 1 | Address latch strobe |
| wr_n | output | 1 | Write strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| pin_override | output | 1 | Bus pins taken over from normal port control |
| hi_oe | output | 1 | Output enable for the high address pins |

## Verification
A request sampled valid at a rising edge while the controller is free shows its address cycle in the very next cycle. Its strobe cycles follow at once, and ready comes 1+W cycles after the address cycle for a read and 2+W for a write, followed by one idle cycle for code 11. Register writes take effect on the writing edge, so the override flags and readback change in the cycle that follows, while cfg_rdata follows cfg_sel with no delay. The bench model lays out the expected bus values for each future cycle at the edge that accepts a request, and it compares every output at each falling edge, midway through the cycle in which each value is due.

// File: rtl/xmem_pkg.sv
// Shared types for the external memory bus controller.
// Assumes an 8-bit register file and a 2-bit wait code per sector.
package xmem_pkg;

    typedef enum logic [2:0] {
        ST_FREE,
        ST_ADDR,
        ST_STRB,
        ST_HOLD,
        ST_GAP
    } bus_state_t;

    typedef struct packed {
        logic       enable;
        logic       legacy;
        logic       legacy_wait;
        logic [2:0] limit;
        logic [1:0] lo_wait;
        logic [1:0] hi_wait;
    } xmem_cfg_t;

    localparam int REG_W = 8;

endpackage

// File: rtl/xmem_cfg_regs.sv
// Control register pair for the bus controller.
// CTRL (sel 0): bit7 enable, bit6 legacy wait bit, bit0 legacy mode.
// SECT (sel 1): bits6:4 sector limit, bits3:2 lower wait, bits1:0 upper wait.
// Assumes writes happen while no access is in flight; reserved bits are not stored.
module xmem_cfg_regs
    import xmem_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             sel,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output xmem_cfg_t        cfg
);

    // Store only the implemented fields of the addressed register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (we) begin
            if (!sel) begin
                cfg.enable      <= wdata[7];
                cfg.legacy_wait <= wdata[6];
                cfg.legacy      <= wdata[0];
            end else begin
                cfg.limit   <= wdata[6:4];
                cfg.lo_wait <= wdata[3:2];
                cfg.hi_wait <= wdata[1:0];
            end
        end
    end

    // Readback mux with reserved positions tied to zero.
    always_comb begin
        if (sel) rdata = {1'b0, cfg.limit, cfg.lo_wait, cfg.hi_wait};
        else     rdata = {cfg.enable, cfg.legacy_wait, 5'b0, cfg.legacy};
    end

endmodule

// File: rtl/xmem_wait_sel.sv
// Chooses the wait behaviour for one address.
// Sector mode: limit L>0 puts offsets below L << SECTOR_SHIFT in the lower
// sector; L=0 means a single sector using the upper field. Legacy mode uses
// one bit for all addresses. Assumes EXT_BASE is the bottom of the range.
module xmem_wait_sel
    import xmem_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int SECTOR_SHIFT = 13,
    parameter int EXT_BASE     = 0
) (
    input  logic [ADDR_W-1:0] addr,
    input  xmem_cfg_t         cfg,
    output logic [1:0]        extra,
    output logic              gap
);

    localparam int BW = ADDR_W + 4;

    logic [BW-1:0] offset;
    logic [BW-1:0] bound;
    logic          in_lower;
    logic [1:0]    code;

    // Sector decode relative to the bottom of the external range.
    always_comb begin
        offset   = BW'(addr - ADDR_W'(EXT_BASE));
        bound    = BW'(cfg.limit) << SECTOR_SHIFT;
        in_lower = (cfg.limit != 3'd0) && (offset < bound);
        code     = in_lower ? cfg.lo_wait : cfg.hi_wait;
    end

    // Map the selected code (or the legacy bit) to strobe stretch and idle gap.
    always_comb begin
        if (cfg.legacy) begin
            extra = {1'b0, cfg.legacy_wait};
            gap   = 1'b0;
        end else begin
            unique case (code)
                2'b00:   extra = 2'd0;
                2'b01:   extra = 2'd1;
                default: extra = 2'd2;
            endcase
            gap = (code == 2'b11);
        end
    end

endmodule

// File: rtl/xmem_bus_fsm.sv
// Bus sequencer: address cycle, stretched strobe, write hold, optional gap.
// Accepts a request only when free and enabled; the wait count is captured
// at acceptance. Read data passes through from the bus in the ready cycle.
module xmem_bus_fsm
    import xmem_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        extra,
    input  logic              gap,
    input  logic [DATA_W-1:0] ad_in,
    output logic              req_ready,
    output logic [DATA_W-1:0] req_rdata,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic              ale,
    output logic              wr_n,
    output logic              rd_n
);

    bus_state_t        state;
    logic [ADDR_W-1:0] lat_addr;
    logic [DATA_W-1:0] lat_wdata;
    logic              lat_we;
    logic              lat_gap;
    logic [1:0]        cnt;

    // State sequencing and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_FREE;
            lat_addr  <= '0;
            lat_wdata <= '0;
            lat_we    <= 1'b0;
            lat_gap   <= 1'b0;
            cnt       <= '0;
        end else begin
            unique case (state)
                ST_FREE: if (enable && req_valid) begin
                    lat_addr  <= req_addr;
                    lat_wdata <= req_wdata;
                    lat_we    <= req_we;
                    lat_gap   <= gap;
                    cnt       <= extra;
                    state     <= ST_ADDR;
                end
                ST_ADDR: state <= ST_STRB;
                ST_STRB: begin
                    if (cnt == 2'd0)
                        state <= lat_we ? ST_HOLD : (lat_gap ? ST_GAP : ST_FREE);
                    else
                        cnt <= cnt - 2'd1;
                end
                ST_HOLD: state <= lat_gap ? ST_GAP : ST_FREE;
                default: state <= ST_FREE;
            endcase
        end
    end

    // Pin and handshake decode from the current phase.
    always_comb begin
        ale       = 1'b0;
        wr_n      = 1'b1;
        rd_n      = 1'b1;
        ad_oe     = 1'b0;
        ad_out    = '0;
        a_hi      = '0;
        req_ready = 1'b0;
        req_rdata = '0;
        unique case (state)
            ST_ADDR: begin
                ale    = 1'b1;
                ad_oe  = 1'b1;
                ad_out = lat_addr[DATA_W-1:0];
                a_hi   = lat_addr[ADDR_W-1:DATA_W];
            end
            ST_STRB: begin
                a_hi = lat_addr[ADDR_W-1:DATA_W];
                if (lat_we) begin
                    wr_n   = 1'b0;
                    ad_oe  = 1'b1;
                    ad_out = lat_wdata;
                end else begin
                    rd_n = 1'b0;
                    if (cnt == 2'd0) begin
                        req_ready = 1'b1;
                        req_rdata = ad_in;
                    end
                end
            end
            ST_HOLD: begin
                a_hi      = lat_addr[ADDR_W-1:DATA_W];
                ad_oe     = 1'b1;
                ad_out    = lat_wdata;
                req_ready = 1'b1;
            end
            default: ;
        endcase
    end

    AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) ale |=> !ale); // R3
    AST_STROBE_AFTER_ALE: assert property (@(posedge clk) disable iff (!rst_n) ($fell(wr_n) || $fell(rd_n)) |-> $past(ale)); // R3
    AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) $rose(wr_n) |-> (ad_oe && req_ready)); // R4
    AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) !rd_n |-> !ad_oe); // R5
    AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n) req_ready |=> !req_ready); // R11
    AST_NO_START_OFF: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_FREE && !enable) |=> !ale); // R2

endmodule

// File: rtl/xmem_bus_ctrl.sv
// Top of the external memory bus controller: register pair, wait selector
// and bus sequencer. Pin ownership is reported as override/enable flags only.
module xmem_bus_ctrl
    import xmem_pkg::*;
#(
    parameter int ADDR_W       = 16,
    parameter int DATA_W       = 8,
    parameter int SECTOR_SHIFT = 13,
    parameter int EXT_BASE     = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [DATA_W-1:0] req_rdata,
    output logic [DATA_W-1:0] ad_out,
    input  logic [DATA_W-1:0] ad_in,
    output logic              ad_oe,
    output logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic              ale,
    output logic              wr_n,
    output logic              rd_n,
    output logic              pin_override,
    output logic              hi_oe
);

    xmem_cfg_t  cfg;
    logic [1:0] extra;
    logic       gap;

    xmem_cfg_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .cfg   (cfg)
    );

    xmem_wait_sel #(
        .ADDR_W       (ADDR_W),
        .SECTOR_SHIFT (SECTOR_SHIFT),
        .EXT_BASE     (EXT_BASE)
    ) u_wsel (
        .addr  (req_addr),
        .cfg   (cfg),
        .extra (extra),
        .gap   (gap)
    );

    xmem_bus_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (cfg.enable),
        .req_valid (req_valid),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .extra     (extra),
        .gap       (gap),
        .ad_in     (ad_in),
        .req_ready (req_ready),
        .req_rdata (req_rdata),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .a_hi      (a_hi),
        .ale       (ale),
        .wr_n      (wr_n),
        .rd_n      (rd_n)
    );

    // Pin ownership follows the enable bit.
    assign pin_override = cfg.enable;
    assign hi_oe        = cfg.enable;

endmodule

// File: tb/sim_xmem_bus_ctrl.sv
module sim_xmem_bus_ctrl;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [7:0] cfg_wdata = '0, cfg_rdata;
    logic       req_valid = 1'b0, req_we = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0] req_wdata = '0, req_rdata, ad_out, ad_in = '0, a_hi;
    logic       req_ready, ad_oe, ale, wr_n, rd_n, pin_override, hi_oe;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xmem_bus_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
        .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .req_rdata(req_rdata), .ad_out(ad_out),
        .ad_in(ad_in), .ad_oe(ad_oe), .a_hi(a_hi), .ale(ale), .wr_n(wr_n),
        .rd_n(rd_n), .pin_override(pin_override), .hi_oe(hi_oe)
    );

    typedef struct {
        bit ale, wr_n, rd_n, oe, rdy;
        bit [7:0] ad, hi, rd;
    } exp_t;

    exp_t q[$];
    bit   free_c = 1;
    bit   m_en, m_leg, m_lw;
    bit [2:0] m_lim;
    bit [1:0] m_lo, m_hi;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic exp_t idle_e();
        exp_t e;
        e.ale = 0; e.wr_n = 1; e.rd_n = 1; e.oe = 0; e.rdy = 0;
        e.ad = 0; e.hi = 0; e.rd = 0;
        return e;
    endfunction

    // Expected cycle sequence of one access, queued at acceptance (R3..R9).
    function automatic void push_access(bit we, bit [15:0] a, bit [7:0] wd, bit [7:0] rv);
        int code, extra;
        bit gap;
        exp_t e;
        if (m_leg) begin
            extra = m_lw; gap = 0;
        end else begin
            code  = (m_lim != 0 && int'(a) < int'(m_lim) * 8192) ? m_lo : m_hi;
            extra = (code == 0) ? 0 : (code == 1) ? 1 : 2;
            gap   = (code == 3);
        end
        e = idle_e(); e.ale = 1; e.oe = 1; e.ad = a[7:0]; e.hi = a[15:8];
        q.push_back(e);
        for (int i = 0; i <= extra; i++) begin
            e = idle_e(); e.hi = a[15:8];
            if (we) begin e.wr_n = 0; e.oe = 1; e.ad = wd; end
            else begin
                e.rd_n = 0;
                if (i == extra) begin e.rdy = 1; e.rd = rv; end
            end
            q.push_back(e);
        end
        if (we) begin
            e = idle_e(); e.hi = a[15:8]; e.oe = 1; e.ad = wd; e.rdy = 1;
            q.push_back(e);
        end
        if (gap) q.push_back(idle_e());
    endfunction

    // Reference model: acceptance and shadow registers at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            {m_en, m_leg, m_lw, m_lim, m_lo, m_hi} = '0;
        end else begin
            if (free_c && req_valid && m_en) push_access(req_we, req_addr, req_wdata, ad_in);
            if (cfg_we) begin
                if (!cfg_sel) begin m_en = cfg_wdata[7]; m_lw = cfg_wdata[6]; m_leg = cfg_wdata[0]; end
                else begin m_lim = cfg_wdata[6:4]; m_lo = cfg_wdata[3:2]; m_hi = cfg_wdata[1:0]; end
            end
        end
    end

    // Per-cycle comparison at the falling edge.
    always @(negedge clk) begin
        exp_t e;
        if (!rst_n || done) begin
            free_c = 1;
        end else begin
            if (q.size() > 0) begin e = q.pop_front(); free_c = 0; end
            else begin e = idle_e(); free_c = 1; end
            check("R2 pin_override", pin_override, m_en);
            check("R2 hi_oe", hi_oe, m_en);
            check("R3 ale", ale, e.ale);
            check("R3 ad_out", ad_out, e.ad);
            check("R3 a_hi", a_hi, e.hi);
            check("R4 wr_n", wr_n, e.wr_n);
            check("R5 rd_n", rd_n, e.rd_n);
            check("R5 ad_oe", ad_oe, e.oe);
            check("R5 req_rdata", req_rdata, e.rd);
            check("R11 req_ready", req_ready, e.rdy);
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic wr_cfg(input bit sel, input bit [7:0] d);
        cfg_sel = sel; cfg_wdata = d; cfg_we = 1;
        step();
        cfg_we = 0;
    endtask

    task automatic rd_cfg(input bit sel, input bit [7:0] exp, input string req);
        cfg_sel = sel; #1;
        check(req, cfg_rdata, exp);
    endtask

    // Present a request and wait for its ready pulse; valid stays high.
    task automatic issue(input bit we, input bit [15:0] a, input bit [7:0] wd, input bit [7:0] rv);
        req_valid = 1; req_we = we; req_addr = a; req_wdata = wd; ad_in = rv;
        for (int n = 0; n < 30; n++) begin
            step();
            if (req_ready) return;
        end
        check("R11 ready timeout", 0, 1);
    endtask

    task automatic drop();
        req_valid = 0;
        step();
    endtask

    initial begin
        repeat (3) step();
        // R1: reset values at the pins and registers
        check("R1 pin_override", pin_override, 0);
        check("R1 wr_n", wr_n, 1);
        check("R1 rd_n", rd_n, 1);
        check("R1 ale", ale, 0);
        rst_n = 1;
        rd_cfg(0, 8'h00, "R1 ctrl");
        rd_cfg(1, 8'h00, "R1 sect");
        // R2: a request while disabled never starts
        req_valid = 1; req_addr = 16'h1234;
        repeat (5) step();
        req_valid = 0;
        step();
        // R10: reserved bits read zero
        wr_cfg(0, 8'hFF); rd_cfg(0, 8'hC1, "R10 ctrl");
        wr_cfg(1, 8'hFF); rd_cfg(1, 8'h7F, "R10 sect");
        // R6, R8: limit 0, sweep upper wait codes
        wr_cfg(0, 8'h80);
        for (int c = 0; c < 4; c++) begin
            wr_cfg(1, 8'(8'h0C | c));
            issue(1, 16'h4321 + 16'(c), 8'hA0 + 8'(c), 8'h00);
            issue(0, 16'hF00F - 16'(c), 8'h00, 8'h5A + 8'(c));
            drop();
        end
        // R7: limit 3, lower code 01, upper code 10; boundary addresses
        wr_cfg(1, 8'h36);
        issue(0, 16'h5FFF, 8'h00, 8'h11);
        issue(0, 16'h6000, 8'h00, 8'h22);
        issue(1, 16'h0000, 8'h33, 8'h00);
        issue(1, 16'hFFFF, 8'h44, 8'h00);
        drop();
        // R7: limit 7, lower code 11 gives gap, upper 00
        wr_cfg(1, 8'h7C);
        issue(1, 16'hDFFF, 8'h55, 8'h00);
        issue(0, 16'hE000, 8'h00, 8'h66);
        drop();
        // R8: limit 0 ignores lower field
        wr_cfg(1, 8'h0C);
        issue(0, 16'h0010, 8'h00, 8'h77);
        drop();
        // R9: legacy mode with wait bit 1 then 0, sectors ignored
        wr_cfg(1, 8'h1F);
        wr_cfg(0, 8'hC1);
        issue(0, 16'h0100, 8'h00, 8'h88);
        issue(1, 16'hC000, 8'h99, 8'h00);
        drop();
        wr_cfg(0, 8'h81);
        issue(1, 16'h0200, 8'hAA, 8'h00);
        drop();
        // R11: back-to-back with gap (code 11) and valid held
        wr_cfg(0, 8'h80);
        wr_cfg(1, 8'h03);
        issue(0, 16'h1357, 8'h00, 8'hBB);
        issue(1, 16'h2468, 8'hCC, 8'h00);
        issue(0, 16'h369C, 8'h00, 8'hDD);
        drop();
        // R2: disabling releases the pins
        wr_cfg(0, 8'h00);
        req_valid = 1; req_addr = 16'h0F0F;
        repeat (4) step();
        req_valid = 0;
        repeat (3) step();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule